// File: doc/BRIEF.md
# Deactivate-Register Write Access Arbiter

This block rules on a software write to the interrupt-deactivate system register. On each request it reads the writer's privilege level, the presence of the needed architectural features, the execution state of the hypervisor and monitor levels, and the trap, routing and interface-enable control bits. It then names exactly one result:

- undefined instruction
- trap to the hypervisor, with its syndrome code
- trap to the monitor
- write to the virtual copy of the register
- write to the physical register

The checks run in a fixed priority order. Undefined, trap and redirect results are interleaved in that order.

The result is computed combinationally and held in a register. It appears on five one-hot outputs, with a valid strobe, one cycle after the request strobe. The exception entry logic and the register contents are handled elsewhere. A separate flag decides what happens when both interrupt-routing bits send the access to the monitor: the access is either trapped to the monitor or made undefined.

Top module: `dir_write_gate`

## Requirements
- R1: If either `has_aa32_l1` or `has_irq_if` is low, the result is undefined at every level.
- R2: A request at level 0 is always undefined.
- R3: At level 1 the access is undefined when all of these hold: the monitor level is present, `undef_prio_flag` is high, and both routing bits are set. If the monitor level is 32-bit, both this check and the R8 check also need `in_monitor_mode` low.
- R4: At level 1, when the hypervisor is enabled and its coprocessor-trap bit (control bit 0) is set, the access traps to the hypervisor. This check comes before R5.
- R5: At level 1, with no R3 or R4 hit, a low `sysreg_en[0]` makes the access undefined.
- R6: At level 1, when the hypervisor is enabled and control bit 1 (deactivate trap) or bit 2 (common trap) is set, the access traps to the hypervisor. This check comes before R7.
- R7: At level 1, when the hypervisor is enabled and control bit 3 (FIQ override) or bit 4 (IRQ override) is set, the write goes to the virtual register. This check comes before R8.
- R8: At levels 1 and 2, with both routing bits set (bit 0 IRQ, bit 1 FIQ), the access is undefined when `undef_route_flag` is high. Otherwise it traps to the monitor.
- R9: At level 2 the checks run in this order:
  - the R3-style check, with no monitor-mode exemption
  - `sysreg_en[1]` low gives undefined
  - the R8 check
  - otherwise a physical write

  Hypervisor control bits have no effect at level 2.
- R10: At level 3, a low `sysreg_en[2]` gives undefined; otherwise the result is a physical write. Routing bits have no effect at level 3.
- R11: Outputs are registered. `out_valid` and exactly one result output are high in the cycle after a cycle with `req_valid` high; all are low otherwise and during reset. `out_syndrome` is 3 with a hypervisor trap and 0 otherwise.
- R12: Hypervisor checks apply only when `hyp_enable` is high. They use `hctl32` when `l2_is_32` is high, else `hctl64`. Routing uses `route32` when `l3_is_32` is high, else `route64`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A write request is presented this cycle |
| cur_level | input | 2 | Privilege level of the writer, 0 to 3 |
| has_aa32_l1 | input | 1 | 32-bit level-1 support present |
| has_irq_if | input | 1 | System-register interrupt interface present |
| l3_present | input | 1 | Monitor level implemented |
| l3_is_32 | input | 1 | Monitor level runs in 32-bit state |
| in_monitor_mode | input | 1 | Core is in 32-bit monitor mode |
| undef_prio_flag | input | 1 | Early undefined check on monitor routing enabled |
| undef_route_flag | input | 1 | Monitor routing yields undefined instead of a trap |
| hyp_enable | input | 1 | Hypervisor level enabled |
| l2_is_32 | input | 1 | Hypervisor level runs in 32-bit state |
| route64 | input | 2 | 64-bit routing bits: bit 0 IRQ, bit 1 FIQ |
| route32 | input | 2 | 32-bit routing bits: bit 0 IRQ, bit 1 FIQ |
| hctl64 | input | 5 | 64-bit hypervisor controls: coproc trap, deactivate trap, common trap, FIQ override, IRQ override (bits 0..4) |
| hctl32 | input | 5 | 32-bit hypervisor controls, same layout |
| sysreg_en | input | 3 | Register-interface enable for levels 1, 2, 3 (bits 0..2) |
| out_valid | output | 1 | A result is held this cycle |
| out_undef | output | 1 | Result: undefined instruction |
| out_hyp_trap | output | 1 | Result: trap to hypervisor |
| out_mon_trap | output | 1 | Result: trap to monitor |
| out_virt_wr | output | 1 | Result: write to virtual register |
| out_phys_wr | output | 1 | Result: write to physical register |
| out_syndrome | output | 6 | Hypervisor trap syndrome code |

## Verification
The assertions assume that every input is stable and known in any cycle where `req_valid` is high. They also assume that `cur_level` is meaningful only in such cycles, since the result register samples it exactly then.

The stimulus changes inputs only on the falling clock edge. It raises `req_valid` with a full, consistent control set each time, and it holds reset for whole cycles. Each assertion therefore sees a settled request, and its result one edge later.

// File: rtl/dir_gate_pkg.sv
// Package: shared result encoding and control-field positions for the
// deactivate-register write arbiter.
// Assumes: hypervisor control vectors follow the bit layout below.
package dir_gate_pkg;

    // Hypervisor control field positions (shared by both state variants)
    localparam int HC_CP_TRAP  = 0;
    localparam int HC_DIR_TRAP = 1;
    localparam int HC_ALL_TRAP = 2;
    localparam int HC_FIQ_OVR  = 3;
    localparam int HC_IRQ_OVR  = 4;
    localparam int HCTL_W      = 5;

    // Routing field positions
    localparam int RT_IRQ = 0;
    localparam int RT_FIQ = 1;
    localparam int RT_W   = 2;

    // Interface-enable positions, one per level 1..3
    localparam int EN_L1 = 0;
    localparam int EN_L2 = 1;
    localparam int EN_L3 = 2;
    localparam int EN_W  = 3;

    typedef enum logic [2:0] {
        RES_PHYS  = 3'd0,
        RES_VIRT  = 3'd1,
        RES_MON   = 3'd2,
        RES_HYP   = 3'd3,
        RES_UNDEF = 3'd4
    } result_e;

    typedef struct packed {
        logic phys;
        logic virt;
        logic mon;
        logic hyp;
        logic undef;
    } result_oh_t;

    // Expand an encoded result into its one-hot form
    function automatic result_oh_t to_onehot(result_e r);
        result_oh_t oh;
        oh       = '0;
        oh.phys  = (r == RES_PHYS);
        oh.virt  = (r == RES_VIRT);
        oh.mon   = (r == RES_MON);
        oh.hyp   = (r == RES_HYP);
        oh.undef = (r == RES_UNDEF);
        return oh;
    endfunction

endpackage

// File: rtl/dir_gate_route.sv
// Module: monitor-routing evaluator.
// Picks the routing-bit set that matches the monitor level's execution
// state and reports whether both IRQ and FIQ route to the monitor.
// Level 1 in 32-bit monitor state is exempt while the core is in monitor
// mode; level 2 has no such exemption.
// Assumes: inputs are settled when the result register samples them.
module dir_gate_route
    import dir_gate_pkg::*;
(
    input  logic            l3_present,
    input  logic            l3_is_32,
    input  logic            in_monitor_mode,
    input  logic [RT_W-1:0] route64,
    input  logic [RT_W-1:0] route32,
    output logic            both_l1,
    output logic            both_l2
);

    logic [RT_W-1:0] sel;
    logic            all_set;

    // Choose the routing set for the monitor level's state
    always_comb begin
        sel     = l3_is_32 ? route32 : route64;
        all_set = l3_present && sel[RT_IRQ] && sel[RT_FIQ];
    end

    // Apply the level-1 monitor-mode exemption for 32-bit monitor state
    always_comb begin
        both_l1 = all_set && !(l3_is_32 && in_monitor_mode);
        both_l2 = all_set;
    end

endmodule

// File: rtl/dir_gate_hyp.sv
// Module: hypervisor control evaluator.
// Selects the 32-bit or 64-bit control set for the hypervisor level and
// condenses it into three gated conditions: coprocessor trap, deactivate
// or common trap, and interrupt override.
// Assumes: outputs are meaningful only for level-1 requests.
module dir_gate_hyp
    import dir_gate_pkg::*;
(
    input  logic              hyp_enable,
    input  logic              l2_is_32,
    input  logic [HCTL_W-1:0] hctl64,
    input  logic [HCTL_W-1:0] hctl32,
    output logic              cp_trap,
    output logic              dir_trap,
    output logic              ovr_virt
);

    logic [HCTL_W-1:0] ctl;

    // Choose the control set and gate it by the hypervisor enable
    always_comb begin
        ctl      = hyp_enable ? (l2_is_32 ? hctl32 : hctl64) : '0;
        cp_trap  = ctl[HC_CP_TRAP];
        dir_trap = ctl[HC_DIR_TRAP] || ctl[HC_ALL_TRAP];
        ovr_virt = ctl[HC_FIQ_OVR] || ctl[HC_IRQ_OVR];
    end

endmodule

// File: rtl/dir_gate_prio.sv
// Module: prioritised result selector.
// Walks the fixed check order for each privilege level and returns one
// encoded result. Purely combinational.
// Assumes: route and hypervisor conditions come pre-selected and gated.
module dir_gate_prio
    import dir_gate_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  logic [LVL_W-1:0] level,
    input  logic             feats_ok,
    input  logic             prio_flag,
    input  logic             route_flag,
    input  logic             both_l1,
    input  logic             both_l2,
    input  logic             cp_trap,
    input  logic             dir_trap,
    input  logic             ovr_virt,
    input  logic [EN_W-1:0]  if_en,
    output result_e          result
);

    // Outcome of a both-bits routing hit, shared by levels 1 and 2
    result_e route_res;
    always_comb route_res = route_flag ? RES_UNDEF : RES_MON;

    // Priority walk per privilege level
    always_comb begin
        result = RES_UNDEF;
        if (feats_ok) begin
            unique case (level)
                LVL_W'(1): begin
                    if (prio_flag && both_l1)  result = RES_UNDEF;
                    else if (cp_trap)          result = RES_HYP;
                    else if (!if_en[EN_L1])    result = RES_UNDEF;
                    else if (dir_trap)         result = RES_HYP;
                    else if (ovr_virt)         result = RES_VIRT;
                    else if (both_l1)          result = route_res;
                    else                       result = RES_PHYS;
                end
                LVL_W'(2): begin
                    if (prio_flag && both_l2)  result = RES_UNDEF;
                    else if (!if_en[EN_L2])    result = RES_UNDEF;
                    else if (both_l2)          result = route_res;
                    else                       result = RES_PHYS;
                end
                LVL_W'(3): begin
                    result = if_en[EN_L3] ? RES_PHYS : RES_UNDEF;
                end
                default: result = RES_UNDEF;
            endcase
        end
    end

endmodule

// File: rtl/dir_write_gate.sv
// Module: top of the deactivate-register write arbiter.
// Combines routing and hypervisor evaluation with the priority selector
// and registers a one-hot result plus syndrome one cycle after a request.
// Assumes: synchronous active-low reset; inputs stable while req_valid.
module dir_write_gate
    import dir_gate_pkg::*;
#(
    parameter int          SYND_W   = 6,
    parameter logic [5:0]  HYP_CODE = 6'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        cur_level,
    input  logic              has_aa32_l1,
    input  logic              has_irq_if,
    input  logic              l3_present,
    input  logic              l3_is_32,
    input  logic              in_monitor_mode,
    input  logic              undef_prio_flag,
    input  logic              undef_route_flag,
    input  logic              hyp_enable,
    input  logic              l2_is_32,
    input  logic [1:0]        route64,
    input  logic [1:0]        route32,
    input  logic [4:0]        hctl64,
    input  logic [4:0]        hctl32,
    input  logic [2:0]        sysreg_en,
    output logic              out_valid,
    output logic              out_undef,
    output logic              out_hyp_trap,
    output logic              out_mon_trap,
    output logic              out_virt_wr,
    output logic              out_phys_wr,
    output logic [SYND_W-1:0] out_syndrome
);

    localparam logic [SYND_W-1:0] SYND_HYP = SYND_W'(HYP_CODE);

    logic       both_l1, both_l2;
    logic       cp_trap, dir_trap, ovr_virt;
    logic       feats_ok;
    result_e    result;
    result_oh_t res_q;

    always_comb feats_ok = has_aa32_l1 && has_irq_if;

    dir_gate_route u_route (
        .l3_present      (l3_present),
        .l3_is_32        (l3_is_32),
        .in_monitor_mode (in_monitor_mode),
        .route64         (route64),
        .route32         (route32),
        .both_l1         (both_l1),
        .both_l2         (both_l2)
    );

    dir_gate_hyp u_hyp (
        .hyp_enable (hyp_enable),
        .l2_is_32   (l2_is_32),
        .hctl64     (hctl64),
        .hctl32     (hctl32),
        .cp_trap    (cp_trap),
        .dir_trap   (dir_trap),
        .ovr_virt   (ovr_virt)
    );

    dir_gate_prio #(.LVL_W(2)) u_prio (
        .level      (cur_level),
        .feats_ok   (feats_ok),
        .prio_flag  (undef_prio_flag),
        .route_flag (undef_route_flag),
        .both_l1    (both_l1),
        .both_l2    (both_l2),
        .cp_trap    (cp_trap),
        .dir_trap   (dir_trap),
        .ovr_virt   (ovr_virt),
        .if_en      (sysreg_en),
        .result     (result)
    );

    // Capture the result and syndrome on each request, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            out_valid    <= 1'b0;
            res_q        <= '0;
            out_syndrome <= '0;
        end else begin
            out_valid    <= 1'b1;
            res_q        <= to_onehot(result);
            out_syndrome <= (result == RES_HYP) ? SYND_HYP : '0;
        end
    end

    always_comb begin
        out_undef    = res_q.undef;
        out_hyp_trap = res_q.hyp;
        out_mon_trap = res_q.mon;
        out_virt_wr  = res_q.virt;
        out_phys_wr  = res_q.phys;
    end

    // R11: one result when valid, none otherwise
    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_undef, out_hyp_trap, out_mon_trap, out_virt_wr, out_phys_wr})
            == (out_valid ? 1 : 0));

    // R11: result valid follows the request strobe by one cycle
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R11: syndrome present only with a hypervisor trap
    p_syndrome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_syndrome == (out_hyp_trap ? SYND_HYP : '0));

    // R1: missing features always give undefined
    p_nofeat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(has_aa32_l1 && has_irq_if)) |=> out_undef);

    // R2: level 0 is always undefined
    p_level0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_level == 2'd0) |=> out_undef);

    // R10: enabled level 3 with features present writes the physical register
    p_level3_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_level == 2'd3 && has_aa32_l1 && has_irq_if && sysreg_en[2])
            |=> out_phys_wr);

endmodule

// File: tb/tb_dir_write_gate.sv
`timescale 1ns/1ps
module tb_dir_write_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] cur_level = '0;
    logic       has_aa32_l1 = 1'b0, has_irq_if = 1'b0;
    logic       l3_present = 1'b0, l3_is_32 = 1'b0, in_monitor_mode = 1'b0;
    logic       undef_prio_flag = 1'b0, undef_route_flag = 1'b0;
    logic       hyp_enable = 1'b0, l2_is_32 = 1'b0;
    logic [1:0] route64 = '0, route32 = '0;
    logic [4:0] hctl64 = '0, hctl32 = '0;
    logic [2:0] sysreg_en = '0;
    logic       out_valid, out_undef, out_hyp_trap, out_mon_trap, out_virt_wr, out_phys_wr;
    logic [5:0] out_syndrome;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dir_write_gate dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_level(cur_level),
        .has_aa32_l1(has_aa32_l1), .has_irq_if(has_irq_if),
        .l3_present(l3_present), .l3_is_32(l3_is_32), .in_monitor_mode(in_monitor_mode),
        .undef_prio_flag(undef_prio_flag), .undef_route_flag(undef_route_flag),
        .hyp_enable(hyp_enable), .l2_is_32(l2_is_32),
        .route64(route64), .route32(route32), .hctl64(hctl64), .hctl32(hctl32),
        .sysreg_en(sysreg_en), .out_valid(out_valid), .out_undef(out_undef),
        .out_hyp_trap(out_hyp_trap), .out_mon_trap(out_mon_trap),
        .out_virt_wr(out_virt_wr), .out_phys_wr(out_phys_wr), .out_syndrome(out_syndrome)
    );

    // Expected one-hot: bit0 undef, bit1 hyp, bit2 mon, bit3 virt, bit4 phys
    localparam logic [4:0] U = 5'b00001, H = 5'b00010, M = 5'b00100,
                           V = 5'b01000, P = 5'b10000;

    // Fields: tag | exp | level | {aa32,irqif} | {l3pres,l3_32,mon} |
    // {prio,routeflag} | {hyp_en,l2_32} | route64 | route32 | hctl64 | hctl32 | sysreg_en
    localparam int NV = 25;
    localparam logic [36:0] VECS [NV] = '{
        {4'd1,  U, 2'd1, 2'b01, 3'b100, 2'b00, 2'b00, 2'b00, 2'b00, 5'b00000, 5'b00000, 3'b111}, // R1
        {4'd1,  U, 2'd3, 2'b10, 3'b100, 2'b00, 2'b00, 2'b00, 2'b00, 5'b00000, 5'b00000, 3'b111}, // R1
        {4'd2,  U, 2'd0, 2'b11, 3'b100, 2'b00, 2'b00, 2'b00, 2'b00, 5'b00000, 5'b00000, 3'b111}, // R2
        {4'd10, P, 2'd3, 2'b11, 3'b100, 2'b00, 2'b00, 2'b00, 2'b00, 5'b00000, 5'b00000, 3'b111}, // R10
        {4'd10, U, 2'd3, 2'b11, 3'b100, 2'b00, 2'b00, 2'b00, 2'b00, 5'b00000, 5'b00000, 3'b011}, // R10
        {4'd3,  U, 2'd1, 2'b11, 3'b100, 2'b10, 2'b00, 2'b11, 2'b00, 5'b00000, 5'b00000, 3'b111}, // R3
        {4'd3,  U, 2'd1, 2'b11, 3'b110, 2'b10, 2'b00, 2'b00, 2'b11, 5'b00000, 5'b00000, 3'b111}, // R3
        {4'd3,  P, 2'd1, 2'b11, 3'b111, 2'b10, 2'b00, 2'b00, 2'b11, 5'b00000, 5'b00000, 3'b111}, // R3
        {4'd4,  H, 2'd1, 2'b11, 3'b100, 2'b00, 2'b10, 2'b00, 2'b00, 5'b00001, 5'b00000, 3'b110}, // R4
        {4'd5,  U, 2'd1, 2'b11, 3'b100, 2'b00, 2'b10, 2'b00, 2'b00, 5'b00000, 5'b00000, 3'b110}, // R5
        {4'd12, U, 2'd1, 2'b11, 3'b100, 2'b00, 2'b00, 2'b00, 2'b00, 5'b00001, 5'b00000, 3'b110}, // R12
        {4'd6,  H, 2'd1, 2'b11, 3'b100, 2'b00, 2'b10, 2'b00, 2'b00, 5'b01010, 5'b00000, 3'b111}, // R6
        {4'd6,  H, 2'd1, 2'b11, 3'b100, 2'b00, 2'b11, 2'b00, 2'b00, 5'b00000, 5'b00100, 3'b111}, // R6
        {4'd7,  V, 2'd1, 2'b11, 3'b100, 2'b00, 2'b10, 2'b00, 2'b00, 5'b10000, 5'b00000, 3'b111}, // R7
        {4'd12, P, 2'd1, 2'b11, 3'b100, 2'b00, 2'b11, 2'b00, 2'b00, 5'b11111, 5'b00000, 3'b111}, // R12
        {4'd7,  V, 2'd1, 2'b11, 3'b100, 2'b01, 2'b11, 2'b11, 2'b00, 5'b00000, 5'b01000, 3'b111}, // R7
        {4'd8,  U, 2'd1, 2'b11, 3'b100, 2'b01, 2'b00, 2'b11, 2'b00, 5'b00000, 5'b00000, 3'b111}, // R8
        {4'd8,  M, 2'd1, 2'b11, 3'b100, 2'b00, 2'b00, 2'b11, 2'b00, 5'b00000, 5'b00000, 3'b111}, // R8
        {4'd8,  M, 2'd2, 2'b11, 3'b111, 2'b00, 2'b00, 2'b00, 2'b11, 5'b00000, 5'b00000, 3'b111}, // R8
        {4'd9,  U, 2'd2, 2'b11, 3'b100, 2'b00, 2'b00, 2'b11, 2'b00, 5'b00000, 5'b00000, 3'b101}, // R9
        {4'd9,  P, 2'd2, 2'b11, 3'b100, 2'b00, 2'b00, 2'b00, 2'b00, 5'b00000, 5'b00000, 3'b111}, // R9
        {4'd9,  P, 2'd2, 2'b11, 3'b100, 2'b00, 2'b00, 2'b10, 2'b00, 5'b00000, 5'b00000, 3'b111}, // R9
        {4'd9,  P, 2'd2, 2'b11, 3'b100, 2'b00, 2'b10, 2'b00, 2'b00, 5'b11111, 5'b00000, 3'b111}, // R9
        {4'd3,  P, 2'd1, 2'b11, 3'b100, 2'b10, 2'b00, 2'b01, 2'b00, 5'b00000, 5'b00000, 3'b111}, // R3
        {4'd10, P, 2'd3, 2'b11, 3'b100, 2'b01, 2'b00, 2'b11, 2'b00, 5'b00000, 5'b00000, 3'b111}  // R10
    };

    function automatic logic [4:0] got();
        return {out_phys_wr, out_virt_wr, out_mon_trap, out_hyp_trap, out_undef};
    endfunction

    task automatic check(input logic ok, input int tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [36:0] v);
        cur_level        = v[27:26];
        {has_aa32_l1, has_irq_if}                 = v[25:24];
        {l3_present, l3_is_32, in_monitor_mode}   = v[23:21];
        {undef_prio_flag, undef_route_flag}       = v[20:19];
        {hyp_enable, l2_is_32}                    = v[18:17];
        route64   = v[16:15];
        route32   = v[14:13];
        hctl64    = v[12:8];
        hctl32    = v[7:3];
        sysreg_en = v[2:0];
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL R11: watchdog expired, actual hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        // R11: reset holds outputs low even with a request present
        @(negedge clk);
        apply(VECS[3]);
        req_valid = 1'b1;
        @(negedge clk);
        check(got() == 5'b0 && !out_valid && out_syndrome == 0, 11,
              {2'b0, out_syndrome[0], got()}, 8'h00);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: drive at a falling edge, check at the next one
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            req_valid = 1'b1;
            @(negedge clk);
            check(out_valid && got() == VECS[i][32:28], int'(VECS[i][36:33]),
                  {2'b0, out_valid, got()}, {3'b001, VECS[i][32:28]});
            // R11: syndrome tracks the hypervisor trap
            check(out_syndrome == (VECS[i][29] ? 6'd3 : 6'd0), 11,
                  {2'b0, out_syndrome}, {2'b0, (VECS[i][29] ? 6'd3 : 6'd0)});
        end

        // R11: dropping the request clears every output on the next edge
        req_valid = 1'b0;
        @(negedge clk);
        check(!out_valid && got() == 5'b0 && out_syndrome == 0, 11,
              {2'b0, out_valid, got()}, 8'h00);

        // R11: result appears only after the edge, not combinationally
        apply(VECS[12]);
        req_valid = 1'b1;
        #1;
        check(!out_valid && got() == 5'b0, 11, {2'b0, out_valid, got()}, 8'h00);
        @(negedge clk);
        check(out_valid && got() == H && out_syndrome == 6'd3, 11,
              {out_syndrome[1:0], out_valid, got()}, {2'b11, 1'b1, H});

        // R11: back-to-back requests update every cycle
        apply(VECS[17]);
        @(negedge clk);
        check(got() == M && out_syndrome == 0, 8, {2'b0, out_valid, got()}, {3'b001, M});

        // R11: reset mid-stream clears a held result
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_valid && got() == 5'b0, 11, {2'b0, out_valid, got()}, 8'h00);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule